// File: doc/BRIEF.md
# APB Register Bank with Access Filtering

This block is an APB completer that holds a small set of 32-bit control registers. Writes can update single bytes through the per-lane strobes. Each register has its own latency, which stretches the transfer by holding ready low. Each register also has an access policy. The policy names the address spaces the register accepts and whether it needs a privileged requester. Any transfer that breaks the policy, misses the register map or uses an unaligned address completes with the error flag raised.

The address space of a transfer comes from two request bits: the extension bit `bus_ext_space` and `bus_prot[1]`. A requester that needs privileged access drives `bus_prot[0]` high. Latencies, space masks and privilege needs are elaboration parameters. The block has no software-visible configuration. Outside the completing cycle of a transfer, ready, error and read data all stay low.

Top module: `apb_regbank`

## Requirements
- R1: After reset, every register reads as zero. The outputs `bus_ready`, `bus_err` and `bus_rdata` are all low until an access phase starts.
- R2: A permitted write changes only the bytes whose strobe bit is set: strobe bit n enables data bits [8n+7:8n]. A write with all strobes low leaves the register unchanged.
- R3: In the completing cycle of a permitted read, `bus_rdata` carries the register value. `bus_rdata` is zero in every other cycle, including the completion of writes.
- R4: A permitted transfer to register i holds ready low for exactly LAT_i access cycles, then completes. The defaults give registers 0..7 the latencies 0,1,2,3,0,1,2,3. Ready is high only while select and enable are both high.
- R5: `bus_err` is high only in a completing cycle (select, enable and ready all high). It is low in every other cycle.
- R6: With the default 8-bit address, the mapped addresses are 0x00 to 0x1C, one register per 4 bytes. An access at 0x20 or above completes with an error. Such a write has no effect and such a read returns zero.
- R7: An access whose address bits [1:0] are not zero completes with an error, and a write there does not change any register.
- R8: The address space is {ext, prot[1]}: 00 secure, 01 non-secure, 10 root, 11 realm. By default registers 0 to 3 accept every space, register 4 accepts secure only, register 5 non-secure only, register 6 root only, and register 7 root or realm. A transfer in a refused space gets an error. If it is a write, the register keeps its value. If it is a read, the data is zero.
- R9: By default register 3 requires `bus_prot[0]` = 1 (privileged). An unprivileged access to it completes with an error and does not write. `bus_prot[2]` (instruction or data) has no effect on any outcome.
- R10: A transfer that ends in an error completes in its first access cycle, with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | The completer is selected |
| bus_enable | input | 1 | High in the access phase |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_strb | input | DW/8 | Byte-lane write enables |
| bus_prot | input | 3 | [0] privileged, [1] non-secure, [2] instruction |
| bus_ext_space | input | 1 | Extension bit that selects root or realm space |
| bus_ready | output | 1 | Completion of the access phase |
| bus_rdata | output | DW | Read data, valid only in the completing cycle |
| bus_err | output | 1 | Error response, valid only in the completing cycle |

## Verification
The strobed byte write and the permission refusal act on the same register in the same completing cycle. The lane enables decide which bytes would change, while the policy check decides whether any byte may change. The bench provokes this clash with partial-strobe and full-strobe writes that target registers in refused spaces or without privilege. It then reads the same register back in a permitted space and expects the earlier value, byte for byte. Error completions are also judged by their wait count. A refused access to a slow register must finish with no wait states, even though its latency parameter is non-zero.

// File: rtl/apb_rb_pkg.sv
package apb_rb_pkg;

   typedef enum logic [1:0] {
      SP_SECURE = 2'b00,
      SP_NONSEC = 2'b01,
      SP_ROOT   = 2'b10,
      SP_REALM  = 2'b11
   } space_e;

   localparam int NUM_SPACES = 4;

   function automatic space_e space_of(input logic ext, input logic nonsec);
      return space_e'({ext, nonsec});
   endfunction

endpackage

// File: rtl/apb_rb_decode.sv
module apb_rb_decode
   import apb_rb_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 8,
   parameter int DW   = 32,
   parameter int LW   = 4,
   parameter int IW   = 3,
   parameter logic [NREG*LW-1:0]         LAT   = '0,
   parameter logic [NREG*NUM_SPACES-1:0] SPACE = '1,
   parameter logic [NREG-1:0]            PRIV  = '0
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    prot_lo,
   input  logic          ext,
   output logic [IW-1:0] idx,
   output logic          bad,
   output logic [LW-1:0] lat
);
   localparam int LSB = $clog2(DW / 8);
   localparam int SW  = AW - LSB;

   logic [SW-1:0] slot;
   logic          mapped;
   logic          aligned;
   logic          space_ok;
   logic          priv_ok;
   space_e        spc;
   logic [NUM_SPACES-1:0] allow;

   always_comb begin
      slot     = addr[AW-1:LSB];
      mapped   = int'(slot) < NREG;
      aligned  = addr[LSB-1:0] == '0;
      idx      = mapped ? slot[IW-1:0] : '0;
      spc      = space_of(ext, prot_lo[1]);
      allow    = SPACE[idx*NUM_SPACES +: NUM_SPACES];
      space_ok = allow[spc];
      priv_ok  = !PRIV[idx] || prot_lo[0];
      bad      = !mapped || !aligned || !space_ok || !priv_ok;
      lat      = bad ? '0 : LAT[idx*LW +: LW];
   end

endmodule

// File: rtl/apb_rb_wait.sv
module apb_rb_wait #(
   parameter int LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          setup,
   input  logic          access,
   input  logic [LW-1:0] lat_in,
   output logic          ready
);
   logic [LW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (setup) begin
         remain <= lat_in;
      end else if (access && remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign ready = access && (remain == '0);

endmodule

// File: rtl/apb_rb_regs.sv
module apb_rb_regs #(
   parameter int NREG = 8,
   parameter int DW   = 32,
   parameter int IW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IW-1:0]   idx,
   input  logic [DW-1:0]   wdata,
   input  logic [DW/8-1:0] strb,
   output logic [DW-1:0]   rsel
);
   localparam int NB = DW / 8;

   logic [NREG-1:0][DW-1:0] all_q;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [DW-1:0] q;
      logic          hit;
      assign hit = we && (int'(idx) == r);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (hit) begin
            for (int b = 0; b < NB; b++) begin
               if (strb[b]) q[b*8 +: 8] <= wdata[b*8 +: 8];
            end
         end
      end
      assign all_q[r] = q;
   end

   assign rsel = all_q[idx];

endmodule

// File: rtl/apb_regbank.sv
module apb_regbank
   import apb_rb_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 8,
   parameter int DW   = 32,
   parameter int LW   = 4,
   parameter logic [NREG*LW-1:0]         LAT   = 32'h3210_3210,
   parameter logic [NREG*NUM_SPACES-1:0] SPACE = 32'hC421_FFFF,
   parameter logic [NREG-1:0]            PRIV  = 8'b0000_1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_enable,
   input  logic            bus_write,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   input  logic [DW/8-1:0] bus_strb,
   input  logic [2:0]      bus_prot,
   input  logic            bus_ext_space,
   output logic            bus_ready,
   output logic [DW-1:0]   bus_rdata,
   output logic            bus_err
);
   localparam int LSB = $clog2(DW / 8);
   localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1;

   if (DW < 16 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("apb_regbank: DW must be a power of two of at least 16");
   end
   if (NREG < 1 || NREG > (1 << (AW - LSB))) begin : g_bad_nreg
      $error("apb_regbank: NREG does not fit the address width");
   end
   if (LW < 1 || LW > 8) begin : g_bad_lw
      $error("apb_regbank: LW out of range");
   end

   logic          setup;
   logic          access;
   logic          done;
   logic          bad;
   logic [IW-1:0] idx;
   logic [LW-1:0] lat;
   logic [DW-1:0] rsel;
   logic          unused_instr;

   assign unused_instr = bus_prot[2];
   assign setup  = bus_sel && !bus_enable;
   assign access = bus_sel && bus_enable;

   apb_rb_decode #(
      .NREG(NREG), .AW(AW), .DW(DW), .LW(LW), .IW(IW),
      .LAT(LAT), .SPACE(SPACE), .PRIV(PRIV)
   ) u_dec (
      .addr   (bus_addr),
      .prot_lo(bus_prot[1:0]),
      .ext    (bus_ext_space),
      .idx    (idx),
      .bad    (bad),
      .lat    (lat)
   );

   apb_rb_wait #(.LW(LW)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .setup (setup),
      .access(access),
      .lat_in(lat),
      .ready (bus_ready)
   );

   assign done = bus_ready;

   apb_rb_regs #(.NREG(NREG), .DW(DW), .IW(IW)) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (done && bus_write && !bad),
      .idx  (idx),
      .wdata(bus_wdata),
      .strb (bus_strb),
      .rsel (rsel)
   );

   assign bus_err   = done && bad;
   assign bus_rdata = (done && !bus_write && !bad) ? rsel : '0;

endmodule

// File: rtl/apb_rb_chk.sv
module apb_rb_chk #(
   parameter int NREG = 8,
   parameter int AW   = 8,
   parameter int DW   = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_sel,
   input logic            bus_enable,
   input logic            bus_write,
   input logic [AW-1:0]   bus_addr,
   input logic [DW-1:0]   bus_wdata,
   input logic [DW/8-1:0] bus_strb,
   input logic [2:0]      bus_prot,
   input logic            bus_ext_space,
   input logic            bus_ready,
   input logic [DW-1:0]   bus_rdata,
   input logic            bus_err
);
   localparam int LSB = $clog2(DW / 8);

   logic unused_chk;
   assign unused_chk = ^{bus_wdata, bus_strb, bus_prot, bus_ext_space};

   logic fin;
   assign fin = bus_sel && bus_enable && bus_ready;

   a_r5_err_in_final: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> fin);

   a_r3_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(fin && !bus_write) |-> bus_rdata == '0);

   a_r4_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> (bus_sel && bus_enable));

   a_r6_unmapped_err: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && int'(bus_addr >> LSB) >= NREG) |-> bus_err);

   a_r7_unaligned_err: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && bus_addr[LSB-1:0] != '0) |-> bus_err);

   a_r10_err_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_enable && $past(bus_sel && !bus_enable) && bus_addr[LSB-1:0] != '0)
      |-> bus_ready);

endmodule

bind apb_regbank apb_rb_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_apb_regbank.sv
`timescale 1ns/1ps
module tb_apb_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_enable = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_strb = '0;
   logic [2:0]  bus_prot = '0;
   logic        bus_ext_space = 1'b0;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic        bus_err;

   int checks = 0;
   int failures = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   apb_regbank dut (.*);

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] wd;
      logic [3:0]  strb;
      logic [2:0]  prot;
      logic        ext;
      logic [31:0] rd;
      logic        err;
      logic [3:0]  waits;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h00, 32'h11223344, 4'hF, 3'b000, 1'b0, 32'h0,        1'b0, 4'd0, 4'd2},  // R2 full write
      '{1'b0, 8'h00, 32'h0,        4'h0, 3'b000, 1'b0, 32'h11223344, 1'b0, 4'd0, 4'd3},  // R3
      '{1'b1, 8'h04, 32'hAABBCCDD, 4'h5, 3'b000, 1'b0, 32'h0,        1'b0, 4'd1, 4'd2},  // R2 sparse
      '{1'b0, 8'h04, 32'h0,        4'h0, 3'b000, 1'b0, 32'h00BB00DD, 1'b0, 4'd1, 4'd4},  // R4
      '{1'b1, 8'h08, 32'hFFFFFFFF, 4'h8, 3'b000, 1'b0, 32'h0,        1'b0, 4'd2, 4'd2},  // R2 top lane
      '{1'b0, 8'h08, 32'h0,        4'h0, 3'b000, 1'b0, 32'hFF000000, 1'b0, 4'd2, 4'd4},  // R4
      '{1'b1, 8'h0C, 32'h12345678, 4'hF, 3'b001, 1'b0, 32'h0,        1'b0, 4'd3, 4'd9},  // R9 privileged
      '{1'b0, 8'h0C, 32'h0,        4'h0, 3'b000, 1'b0, 32'h0,        1'b1, 4'd0, 4'd9},  // R9 unprivileged
      '{1'b1, 8'h0C, 32'h0,        4'h3, 3'b000, 1'b0, 32'h0,        1'b1, 4'd0, 4'd10}, // R10
      '{1'b0, 8'h0C, 32'h0,        4'h0, 3'b101, 1'b0, 32'h12345678, 1'b0, 4'd3, 4'd9},  // R9 instr bit
      '{1'b1, 8'h10, 32'hCAFEF00D, 4'hF, 3'b000, 1'b0, 32'h0,        1'b0, 4'd0, 4'd8},  // R8 secure ok
      '{1'b1, 8'h10, 32'h0,        4'hF, 3'b010, 1'b0, 32'h0,        1'b1, 4'd0, 4'd8},  // R8 non-secure refused
      '{1'b0, 8'h10, 32'h0,        4'h0, 3'b000, 1'b1, 32'h0,        1'b1, 4'd0, 4'd8},  // R8 root refused
      '{1'b0, 8'h10, 32'h0,        4'h0, 3'b000, 1'b0, 32'hCAFEF00D, 1'b0, 4'd0, 4'd8},  // R8
      '{1'b1, 8'h14, 32'h55AA55AA, 4'hF, 3'b010, 1'b0, 32'h0,        1'b0, 4'd1, 4'd8},  // R8
      '{1'b0, 8'h14, 32'h0,        4'h0, 3'b000, 1'b0, 32'h0,        1'b1, 4'd0, 4'd10}, // R10
      '{1'b0, 8'h14, 32'h0,        4'h0, 3'b010, 1'b0, 32'h55AA55AA, 1'b0, 4'd1, 4'd8},  // R8
      '{1'b1, 8'h18, 32'h600D0006, 4'hF, 3'b000, 1'b1, 32'h0,        1'b0, 4'd2, 4'd8},  // R8 root
      '{1'b0, 8'h18, 32'h0,        4'h0, 3'b010, 1'b1, 32'h0,        1'b1, 4'd0, 4'd8},  // R8 realm refused
      '{1'b0, 8'h18, 32'h0,        4'h0, 3'b000, 1'b1, 32'h600D0006, 1'b0, 4'd2, 4'd8},  // R8
      '{1'b1, 8'h1C, 32'h77770007, 4'hF, 3'b010, 1'b1, 32'h0,        1'b0, 4'd3, 4'd8},  // R8 realm
      '{1'b0, 8'h1C, 32'h0,        4'h0, 3'b000, 1'b1, 32'h77770007, 1'b0, 4'd3, 4'd8},  // R8
      '{1'b1, 8'h1C, 32'h0,        4'h2, 3'b000, 1'b0, 32'h0,        1'b1, 4'd0, 4'd8},  // R8 secure write refused
      '{1'b1, 8'h20, 32'hDEADBEEF, 4'hF, 3'b000, 1'b0, 32'h0,        1'b1, 4'd0, 4'd6},  // R6
      '{1'b0, 8'h20, 32'h0,        4'h0, 3'b000, 1'b0, 32'h0,        1'b1, 4'd0, 4'd6},  // R6
      '{1'b1, 8'h02, 32'h0,        4'hF, 3'b000, 1'b0, 32'h0,        1'b1, 4'd0, 4'd7},  // R7
      '{1'b0, 8'h00, 32'h0,        4'h0, 3'b000, 1'b0, 32'h11223344, 1'b0, 4'd0, 4'd7},  // R7
      '{1'b1, 8'h00, 32'h0,        4'h0, 3'b000, 1'b0, 32'h0,        1'b0, 4'd0, 4'd2},  // R2 no strobes
      '{1'b0, 8'h00, 32'h0,        4'h0, 3'b000, 1'b0, 32'h11223344, 1'b0, 4'd0, 4'd2}   // R2
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                       input logic [3:0] strb, input logic [2:0] prot, input logic ext,
                       output logic [31:0] rd, output logic er, output int waits);
      @(negedge clk);
      bus_sel = 1'b1; bus_enable = 1'b0; bus_write = wr; bus_addr = addr;
      bus_wdata = wd; bus_strb = wr ? strb : 4'h0; bus_prot = prot; bus_ext_space = ext;
      @(negedge clk);
      bus_enable = 1'b1;
      waits = 0;
      #1;
      while (!bus_ready && waits < 40) begin
         waits++;
         @(negedge clk);
         #1;
      end
      rd = bus_rdata;
      er = bus_err;
      @(negedge clk);
      bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0; bus_strb = 4'h0;
      #1;
      chk(!bus_err && bus_rdata == 32'h0 && !bus_ready, "R5", "idle outputs",
          {bus_rdata[29:0], bus_ready, bus_err}, 32'h0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done_flag) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        er;
      int          w;
      repeat (3) @(negedge clk);
      chk(!bus_ready && !bus_err && bus_rdata == 0, "R1", "outputs in reset",
          {bus_rdata[29:0], bus_ready, bus_err}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_ready && !bus_err && bus_rdata == 0, "R1", "outputs after reset",
          {bus_rdata[29:0], bus_ready, bus_err}, 32'h0);

      // R1: every register reads zero, each read in a space it accepts
      for (int r = 0; r < 8; r++) begin
         xfer(1'b0, 8'(r * 4), 32'h0, 4'h0, {1'b0, r == 5, 1'b1}, r >= 6, rd, er, w);
         chk(rd == 32'h0 && !er, "R1", "reset value", rd, 32'h0);
      end

      // table walk
      for (int i = 0; i < NV; i++) begin
         xfer(VEC[i].wr, VEC[i].addr, VEC[i].wd, VEC[i].strb, VEC[i].prot, VEC[i].ext, rd, er, w);
         chk(er == VEC[i].err, $sformatf("R%0d", VEC[i].req), $sformatf("err vec %0d", i),
             32'(er), 32'(VEC[i].err));
         chk(rd == VEC[i].rd, $sformatf("R%0d", VEC[i].req), $sformatf("rdata vec %0d", i),
             rd, VEC[i].rd);
         chk(w == int'(VEC[i].waits), $sformatf("R%0d", VEC[i].req), $sformatf("waits vec %0d", i),
             32'(w), 32'(VEC[i].waits));
      end

      // R8 with R2: partial-strobe write in refused space leaves reg 5 intact
      xfer(1'b1, 8'h14, 32'h0, 4'h3, 3'b001, 1'b1, rd, er, w);
      chk(er, "R8", "refused strobe write err", 32'(er), 32'h1);
      xfer(1'b0, 8'h14, 32'h0, 4'h0, 3'b010, 1'b0, rd, er, w);
      chk(rd == 32'h55AA55AA, "R8", "reg5 after refused write", rd, 32'h55AA55AA);

      // R10: refused access to slow register 7 finishes with no wait
      xfer(1'b0, 8'h1C, 32'h0, 4'h0, 3'b000, 1'b0, rd, er, w);
      chk(w == 0 && er, "R10", "refused slow reg waits", 32'(w), 32'h0);

      // R1: reset in mid-run clears contents
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      xfer(1'b0, 8'h14, 32'h0, 4'h0, 3'b010, 1'b0, rd, er, w);
      chk(rd == 32'h0 && !er, "R1", "reg5 after second reset", rd, 32'h0);

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule